// File: doc/BRIEF.md
# Serial Converter Command and Readout Interface

This block is the digital serial front end of a 12-bit, two-input sampling converter. A host lowers an active-low select line, toggles a serial clock and shifts a short command into the data input. The block skips any zeros that come before the first one, takes that one as the start marker, and then captures a four-bit command. The command picks the input routing (one channel against ground, or the two channels against each other in either polarity), the order in which the result is returned, and whether the converter should sleep instead of converting. When a conversion is asked for, the block strobes the analog side. It then takes the 12-bit result over a valid/ready handshake and returns it on a data pin that is released whenever the select line is high.

All serial pins are brought into the block's own clock domain through synchronizers. Serial clock edges are found by oversampling, so the system clock must run at least eight times faster than the serial clock. The result port is a valid/ready stream with one transfer per conversion. `res_ready` rises together with `conv_start` and stays high until the analog side presents `res_valid`. The transfer happens on the first clock where both are high, and `res_ready` drops on the next cycle. The analog side may hold off (keep `res_valid` low) for as long as it likes, but result bits that leave the data pin before the transfer read as zero. In practice the transfer must complete within roughly one serial clock period after the strobe. If the select line rises, the pending transfer is abandoned.

Top module: `adc_serial_if`

## Requirements
- R1: During and after reset, until a command arrives, `dout_oe`, `dout`, `conv_start`, `res_ready` and `power_down` are 0 and `mux_sel` is 2'b00.
- R2: `din` is sampled on rising `sclk` edges only while `cs_n` is low. Zeros that come before the first sampled one are skipped, and that first one is the start marker.
- R3: The four bits that follow the start marker are, in order: single-ended select, odd/sign, MSB-only order select, run (1 = convert, 0 = shut down). Every later `din` value in the same frame has no effect on the outputs.
- R4: After capture, `mux_sel[1]` is 1 for a differential measurement and 0 for single-ended. `mux_sel[0]` names the channel on the positive input (0 = CH0, 1 = CH1). `mux_sel` holds its value until the next command is captured.
- R5: When the run bit is 1, `conv_start` pulses high for exactly one clock, and `res_ready` rises in that same cycle.
- R6: The result is taken on the clock where `res_valid` and `res_ready` are both 1, and `res_ready` is 0 on the next clock. Holding `res_valid` low delays the transfer without corrupting the returned data.
- R7: `dout_oe` rises on the first falling `sclk` edge after the run bit, driving one zero (the null bit). Each later falling edge moves to the next output bit. Whenever `dout_oe` is 0, `dout` is 0.
- R8: With the order bit at 1, the twelve result bits follow the null bit MSB first (B11..B0), then zeros until `cs_n` rises.
- R9: With the order bit at 0, B11..B0 are followed by B1..B11 (B0 is not repeated), then zeros.
- R10: With the run bit at 0, no `conv_start` occurs. The output is the null bit, twelve ones, then zeros, and `power_down` is 1 from capture until `cs_n` next falls. A normal conversion works in the very next frame.
- R11: Raising `cs_n` releases the data pin (`dout_oe` = 0) within a few clocks and discards any partly received command. The next frame starts fresh from the start-marker search.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock from the host |
| din | input | 1 | Serial command input |
| dout | output | 1 | Serial result output |
| dout_oe | output | 1 | Output enable for the data pin (0 = high impedance) |
| mux_sel | output | 2 | Input routing: bit 1 = differential, bit 0 = channel on the positive input |
| conv_start | output | 1 | One-clock strobe that starts a conversion |
| power_down | output | 1 | Sleep request to the analog side |
| res_data | input | DATA_W (12) | Conversion result |
| res_valid | input | 1 | Result present on `res_data` |
| res_ready | output | 1 | Block waiting for a result |

## Verification
The checker enforces on every cycle the rules that hold regardless of the command: the single-clock width of the strobe, `res_ready` appearing only with a strobe and dropping after a transfer, no strobe while sleeping, a quiet `dout` whenever the pin is released, a steady `mux_sel` while data is shifted out, and release of the pin once `cs_n` has been high long enough. Leading-zero skipping, command field order, the exact bit sequences of the two orders and of the shutdown word, tolerance of a delayed result, and recovery after an aborted frame depend on whole serial frames. The bench's scenarios cover these by comparing complete output streams.

// File: rtl/adc_if_pkg.sv
package adc_if_pkg;

  // Command fields in arrival order; the first bit after the start marker
  // lands in the most significant position.
  typedef struct packed {
    logic single_end;  // 1: channel vs ground, 0: channel pair
    logic odd_sign;    // channel / polarity pick
    logic msb_only;    // 1: MSB-first then zero fill, 0: add reversed copy
    logic run;         // 1: convert, 0: shut down for this frame
  } cmd_t;

  localparam int CMD_BITS = $bits(cmd_t);

  typedef enum logic [1:0] {
    RX_HUNT = 2'd0,
    RX_WORD = 2'd1,
    RX_DONE = 2'd2
  } rx_state_t;

  // {differential, positive-input channel}
  function automatic logic [1:0] route_of(input cmd_t c);
    return {~c.single_end, c.odd_sign};
  endfunction

endpackage

// File: rtl/adc_bit_sync.sv
module adc_bit_sync #(
  parameter int STAGES = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= RST_VAL;
          else        chain[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[i] <= RST_VAL;
          else        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/adc_cmd_rx.sv
module adc_cmd_rx
  import adc_if_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic frame_on,
  input  logic sclk_rise,
  input  logic din_s,
  output logic cap_pulse,
  output logic armed,
  output cmd_t cmd
);
  localparam int CNT_W = $clog2(CMD_BITS);

  rx_state_t             st;
  logic [CNT_W-1:0]      cnt;
  logic [CMD_BITS-2:0]   sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= RX_HUNT;
      cnt       <= '0;
      sh        <= '0;
      cap_pulse <= 1'b0;
      cmd       <= '0;
    end else begin
      cap_pulse <= 1'b0;
      if (!frame_on) begin
        st  <= RX_HUNT;
        cnt <= '0;
      end else if (sclk_rise) begin
        case (st)
          RX_HUNT: if (din_s) begin
            st  <= RX_WORD;
            cnt <= '0;
          end
          RX_WORD: begin
            sh <= {sh[CMD_BITS-3:0], din_s};
            if (cnt == CNT_W'(CMD_BITS - 1)) begin
              st        <= RX_DONE;
              cap_pulse <= 1'b1;
              cmd       <= cmd_t'({sh, din_s});
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign armed = (st == RX_DONE);
endmodule

// File: rtl/adc_out_seq.sv
module adc_out_seq #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_on,
  input  logic              sclk_fall,
  input  logic              armed,
  input  logic              msb_only,
  input  logic              all_ones,
  input  logic [DATA_W-1:0] data,
  output logic              dout,
  output logic              dout_oe
);
  // slot 0: null, 1..W: MSB-first, W+1..2W-1: reversed copy, 2W: fill
  localparam int LAST   = 2 * DATA_W;
  localparam int SLOT_W = $clog2(LAST + 1);

  logic [SLOT_W-1:0] slot;
  logic [SLOT_W-1:0] slot_nx;

  function automatic logic bit_at(input logic [SLOT_W-1:0] s,
                                  input logic ord, input logic ones,
                                  input logic [DATA_W-1:0] d);
    int si;
    si = int'(s);
    if (si == 0)                   return 1'b0;
    if (si <= DATA_W)              return ones ? 1'b1 : d[DATA_W - si];
    if (si < LAST && !ord && !ones) return d[si - DATA_W];
    return 1'b0;
  endfunction

  assign slot_nx = (slot == SLOT_W'(LAST)) ? slot : slot + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot    <= '0;
      dout    <= 1'b0;
      dout_oe <= 1'b0;
    end else if (!frame_on) begin
      slot    <= '0;
      dout    <= 1'b0;
      dout_oe <= 1'b0;
    end else if (sclk_fall && armed) begin
      if (!dout_oe) begin
        dout_oe <= 1'b1;
        slot    <= '0;
        dout    <= 1'b0;
      end else begin
        slot <= slot_nx;
        dout <= bit_at(slot_nx, msb_only, all_ones, data);
      end
    end
  end
endmodule

// File: rtl/adc_serial_if.sv
module adc_serial_if
  import adc_if_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              din,
  output logic              dout,
  output logic              dout_oe,
  output logic [1:0]        mux_sel,
  output logic              conv_start,
  output logic              power_down,
  input  logic [DATA_W-1:0] res_data,
  input  logic              res_valid,
  output logic              res_ready
);
  logic cs_s, sclk_s, din_s;
  logic sclk_q, on_q;
  logic frame_on, frame_begin, sclk_rise, sclk_fall;
  logic cap_pulse, armed;
  cmd_t cmd;
  logic [DATA_W-1:0] res_q;

  adc_bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs (
    .clk(clk), .rst_n(rst_n), .d(cs_n), .q(cs_s));
  adc_bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sclk (
    .clk(clk), .rst_n(rst_n), .d(sclk), .q(sclk_s));
  adc_bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_din (
    .clk(clk), .rst_n(rst_n), .d(din), .q(din_s));

  assign frame_on    = ~cs_s;
  assign frame_begin = frame_on & ~on_q;
  assign sclk_rise   = frame_on & sclk_s & ~sclk_q;
  assign sclk_fall   = frame_on & ~sclk_s & sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      on_q   <= 1'b0;
    end else begin
      sclk_q <= sclk_s;
      on_q   <= frame_on;
    end
  end

  adc_cmd_rx u_rx (
    .clk(clk), .rst_n(rst_n), .frame_on(frame_on), .sclk_rise(sclk_rise),
    .din_s(din_s), .cap_pulse(cap_pulse), .armed(armed), .cmd(cmd));

  // Routing, strobe, sleep flag and result stream
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mux_sel    <= 2'b00;
      conv_start <= 1'b0;
      power_down <= 1'b0;
      res_ready  <= 1'b0;
      res_q      <= '0;
    end else begin
      conv_start <= cap_pulse & cmd_run_now(cap_pulse);
      if (cap_pulse) mux_sel <= route_of(cmd_now);
      if (frame_begin)                 power_down <= 1'b0;
      else if (cap_pulse && !cmd_now.run) power_down <= 1'b1;
      if (cap_pulse) res_q <= '0;
      else if (res_valid && res_ready) res_q <= res_data;
      if (cap_pulse && cmd_now.run)          res_ready <= 1'b1;
      else if (!frame_on || res_valid)       res_ready <= 1'b0;
    end
  end

  // cmd is registered in the receiver together with cap_pulse
  cmd_t cmd_now;
  assign cmd_now = cmd;

  function automatic logic cmd_run_now(input logic p);
    return p & cmd.run;
  endfunction

  adc_out_seq #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .frame_on(frame_on), .sclk_fall(sclk_fall),
    .armed(armed), .msb_only(cmd.msb_only), .all_ones(~cmd.run),
    .data(res_q), .dout(dout), .dout_oe(dout_oe));

endmodule

// File: rtl/adc_serial_if_chk.sv
module adc_serial_if_chk #(
  parameter int SYNC_STAGES = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       dout,
  input logic       dout_oe,
  input logic [1:0] mux_sel,
  input logic       conv_start,
  input logic       power_down,
  input logic       res_valid,
  input logic       res_ready
);
  localparam int LIM = SYNC_STAGES + 3;
  logic [7:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                  hi_cnt <= '0;
    else if (!cs_n)              hi_cnt <= '0;
    else if (hi_cnt != 8'hFF)    hi_cnt <= hi_cnt + 1'b1;

  assert_strobe_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);
  assert_ready_with_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_ready) |-> conv_start);
  assert_ready_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_ready && res_valid) |=> !res_ready);
  assert_quiet_pin_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_oe |-> !dout);
  assert_route_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_oe && $past(dout_oe)) |-> $stable(mux_sel));
  assert_sleep_no_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    power_down |-> !conv_start);
  assert_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(hi_cnt) >= LIM) |-> !dout_oe);
endmodule

bind adc_serial_if adc_serial_if_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .dout(dout), .dout_oe(dout_oe),
  .mux_sel(mux_sel), .conv_start(conv_start), .power_down(power_down),
  .res_valid(res_valid), .res_ready(res_ready));

// File: tb/adc_serial_if_tb.sv
module adc_serial_if_tb;
  localparam int W = 12;
  localparam int H = 48;       // half serial period, 6 system clocks
  localparam int NS = 28;      // slots observed per frame
  localparam int NV = 8;
  // {lead zeros[2:0], single_end, odd_sign, msb_only, run, data[11:0]}
  localparam logic [18:0] VEC [NV] = '{
    {3'd0, 1'b1, 1'b0, 1'b1, 1'b1, 12'hA5C},
    {3'd3, 1'b1, 1'b1, 1'b0, 1'b1, 12'h801},
    {3'd1, 1'b0, 1'b0, 1'b1, 1'b1, 12'hFFF},
    {3'd5, 1'b0, 1'b1, 1'b0, 1'b1, 12'h000},
    {3'd2, 1'b1, 1'b0, 1'b0, 1'b1, 12'h3C7},
    {3'd0, 1'b0, 1'b1, 1'b1, 1'b0, 12'h123},
    {3'd7, 1'b1, 1'b1, 1'b1, 1'b1, 12'h001},
    {3'd4, 1'b0, 1'b0, 1'b0, 1'b0, 12'hFFF}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, din = 1'b0;
  logic dout, dout_oe, conv_start, power_down, res_ready;
  logic res_valid = 1'b0;
  logic [1:0] mux_sel;
  logic [W-1:0] res_data = '0, ana_data = '0;
  int ana_delay = 2;
  int conv_cnt = 0, total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  adc_serial_if u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
    .dout(dout), .dout_oe(dout_oe), .mux_sel(mux_sel),
    .conv_start(conv_start), .power_down(power_down),
    .res_data(res_data), .res_valid(res_valid), .res_ready(res_ready));

  // analog stand-in: answers each strobe after ana_delay clocks
  initial forever begin
    @(posedge clk);
    if (conv_start) begin
      conv_cnt++;
      repeat (ana_delay) @(negedge clk);
      res_data  = ana_data;
      res_valid = 1'b1;
      do @(posedge clk); while (!res_ready);
      #1 res_valid = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic exp_bit(input int s, input bit ord, input bit run,
                                   input logic [W-1:0] d);
    if (s == 0) return 1'b0;
    if (s <= W) return run ? d[W - s] : 1'b1;
    if (s < 2 * W && run && !ord) return d[s - W];
    return 1'b0;
  endfunction

  task automatic send_bit(input logic b);
    din = b; #H; sclk = 1'b1; #H; sclk = 1'b0;
  endtask

  task automatic run_frame(input int lead, input bit sgl, input bit odd,
                           input bit ord, input bit run, input logic [W-1:0] d);
    logic [NS-1:0] got, want;
    bit oe_ok;
    int c0;
    ana_data = d;
    c0 = conv_cnt;
    oe_ok = 1;
    cs_n = 1'b0; #(2 * H);
    for (int i = 0; i < lead; i++) send_bit(1'b0);
    send_bit(1'b1); send_bit(sgl); send_bit(odd); send_bit(ord); send_bit(run);
    for (int s = 0; s < NS; s++) begin
      din = (s % 3 != 0);            // junk after the command (R3)
      #H;
      got[s]  = dout;
      want[s] = exp_bit(s, ord, run, d);
      if (!dout_oe) oe_ok = 0;
      sclk = 1'b1; #H; sclk = 1'b0;
    end
    chk(got == want, run ? (ord ? "R8 stream" : "R9 stream") : "R10 stream",
        32'(got), 32'(want));
    chk(oe_ok, "R7 pin driven", 32'(oe_ok), 1);
    chk(mux_sel == {~sgl, odd}, "R4 mux_sel", 32'(mux_sel), 32'({~sgl, odd}));
    chk(conv_cnt - c0 == (run ? 1 : 0), "R5 strobe count",
        32'(conv_cnt - c0), 32'(run ? 1 : 0));
    cs_n = 1'b1; din = 1'b0; #(6 * 8);
    chk(!dout_oe && !dout, "R11 pin released", 32'({dout_oe, dout}), 0);
    chk(power_down == !run, "R10 power_down", 32'(power_down), 32'(!run));
    #(2 * H);
  endtask

  initial begin
    #3;
    #(10 * 8);
    chk({dout_oe, dout, conv_start, res_ready, power_down, mux_sel} == '0,
        "R1 in reset", 32'({dout_oe, dout, conv_start, res_ready, power_down, mux_sel}), 0);
    rst_n = 1'b1;
    #(10 * 8);
    chk({dout_oe, dout, conv_start, res_ready, power_down, mux_sel} == '0,
        "R1 after reset", 32'({dout_oe, dout, conv_start, res_ready, power_down, mux_sel}), 0);

    // vector table: R2 lead zeros, R3 field order, R4, R8, R9, R10
    for (int v = 0; v < NV; v++)
      run_frame(int'(VEC[v][18:16]), VEC[v][15], VEC[v][14], VEC[v][13],
                VEC[v][12], VEC[v][11:0]);

    // R10: sleep clears as soon as the next frame begins
    run_frame(1, 1'b1, 1'b0, 1'b1, 1'b0, 12'h000);
    cs_n = 1'b0; #(8 * 8);
    chk(power_down == 1'b0, "R10 sleep cleared", 32'(power_down), 0);
    cs_n = 1'b1; #(2 * H);
    run_frame(0, 1'b0, 1'b1, 1'b1, 1'b1, 12'h5A6);

    // R6: result delayed by back-pressure on the analog side
    ana_delay = 8;
    run_frame(2, 1'b1, 1'b1, 1'b0, 1'b1, 12'hB4D);
    ana_delay = 2;

    // R11: partial command abandoned by raising cs_n
    cs_n = 1'b0; #(2 * H);
    send_bit(1'b1); send_bit(1'b0);
    cs_n = 1'b1; #(4 * H);
    chk(!dout_oe, "R11 abort no drive", 32'(dout_oe), 0);
    run_frame(0, 1'b1, 1'b0, 1'b0, 1'b1, 12'h6E1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule